// File: doc/BRIEF.md
# Serial Register Bank with Coherent Counter Snapshot

This block is the two-wire serial slave side of a small register bank: sixteen 8-bit locations behind a wrapping word pointer. A write transfer addressed to the device sets the pointer from its first byte and stores every later byte at the pointer. A read transfer returns bytes from the pointer. The pointer steps after each byte in both directions. SCL and SDA are sampled on the system clock. The block pulls SDA low through a single output-enable.

Locations 01 to 07 hold live time counters. Logic outside the block advances them through a load port and sees them on a parallel output. When a read transfer is accepted, all seven counters are frozen into a holding copy. Every counter byte in that transfer comes from the copy, so a multi-byte read never shows a half-carried time. A control bit can blank the year field of location 05 and the weekday field of location 06 on reads only.

Top module: `srb_bank`

## Requirements
- R1: The block acknowledges only the address bytes A2h (write) and A3h (read). After any other address byte it leaves SDA released for the rest of the transfer, until the next START.
- R2: During the ninth clock, SDA is pulled low after an accepted address byte, after the word address byte and after every written data byte.
- R3: The first byte after A2h loads the pointer from its low four bits. Each later byte is written at the pointer, and the pointer then steps by one. The pointer wraps from 0Fh to 00h.
- R4: Read bytes are sent MSB first from the pointer location, and the pointer steps by one after each byte. A read transfer with no word address of its own starts at the current pointer.
- R5: A NACK from the master after a read byte ends the burst, and SDA stays released until the next START. A STOP always releases SDA.
- R6: When A3h is accepted, locations 01 to 07 are copied into a holding copy. Reads of 01 to 07 during that transfer return the copy, even if the live counters change mid-burst.
- R7: A repeated START followed by A3h takes a fresh copy of the counters.
- R8: A serial write to one counter location changes that location only, as seen on `counters_o` (location n is byte n-1).
- R9: When `ld_en_i` is high, `ld_data_i` is stored in counter location `ld_idx_i` (1 to 7). Index 0 has no effect. If a serial write hits the same location in the same cycle, the serial write wins.
- R10: When bit 3 of location 00 is set, reads of 05 return bits 7:6 as 0 and reads of 06 return bits 7:5 as 0. The stored values do not change.
- R11: Location 00 and locations 08 to 0F read back their live stored values.
- R12: After reset all locations and the pointer are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| ld_en_i | input | 1 | Counter load strobe |
| ld_idx_i | input | 3 | Counter location to load (1 to 7) |
| ld_data_i | input | 8 | Counter load value |
| ctrl_o | output | 8 | Location 00 contents |
| counters_o | output | 56 | Live locations 01..07, location n in bits 8n-1:8n-8 |

## Verification
A wrong pointer shows up on the very next byte: the data read back or written lands one location off. A stale or torn holding copy is seen only when a counter changes between the capture and a later byte of the same burst, so the directed tests change counters mid-burst and across repeated STARTs. A framing error in the bit counter or the phase register shows within one byte time, as a missing or misplaced acknowledge, or as SDA driven after a NACK.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_WORD,
        PH_WDAT,
        PH_RDAT,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;
    logic  s_scl, s_sda;

    assign s_scl = q.scl[STAGES-1];
    assign s_sda = q.sda[STAGES-1];

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = s_scl;
        d.sda_p = s_sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = s_sda;
    assign scl_rise_o = s_scl & ~q.scl_p;
    assign scl_fall_o = ~s_scl & q.scl_p;
    assign start_o    = s_scl & q.scl_p & q.sda_p & ~s_sda;
    assign stop_o     = s_scl & q.scl_p & ~q.sda_p & s_sda;
endmodule

// File: rtl/srb_link.sv
module srb_link
    import srb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h51,
    parameter int         AW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [7:0]    rd_byte_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] ptr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          cap_o,
    output phase_e        phase_o
);
    typedef struct packed {
        phase_e        ph;
        logic [3:0]    bits;
        logic          slot;
        logic          mack;
        logic [7:0]    sh;
        logic [7:0]    tx;
        logic          oe;
        logic [AW-1:0] ptr;
        logic          wr;
        logic [AW-1:0] waddr;
        logic [7:0]    wdata;
        logic          cap;
    } link_t;

    link_t q, d;

    always_comb begin
        d     = q;
        d.wr  = 1'b0;
        d.cap = 1'b0;
        if (start_i) begin
            d.ph   = PH_DEV;
            d.bits = '0;
            d.slot = 1'b0;
            d.oe   = 1'b0;
        end else if (stop_i) begin
            d.ph   = PH_IDLE;
            d.bits = '0;
            d.slot = 1'b0;
            d.oe   = 1'b0;
        end else if (q.ph != PH_IDLE) begin
            if (rise_i) begin
                if (!q.slot) begin
                    d.sh   = {q.sh[6:0], sda_s_i};
                    d.bits = q.bits + 4'd1;
                end else begin
                    d.mack = sda_s_i;
                end
            end
            if (fall_i) begin
                if (q.slot) begin
                    d.slot = 1'b0;
                    d.oe   = 1'b0;
                    d.bits = '0;
                    if (q.ph == PH_RDAT) begin
                        if (q.mack) begin
                            d.ph = PH_SKIP;
                        end else begin
                            d.tx = rd_byte_i;
                            d.oe = ~rd_byte_i[7];
                        end
                    end
                end else if (q.bits == 4'd8) begin
                    d.slot = 1'b1;
                    d.mack = 1'b0;
                    unique case (q.ph)
                        PH_DEV: begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.oe = 1'b1;
                                if (q.sh[0]) begin
                                    d.ph  = PH_RDAT;
                                    d.cap = 1'b1;
                                end else begin
                                    d.ph = PH_WORD;
                                end
                            end else begin
                                d.ph = PH_SKIP;
                            end
                        end
                        PH_WORD: begin
                            d.oe  = 1'b1;
                            d.ptr = q.sh[AW-1:0];
                            d.ph  = PH_WDAT;
                        end
                        PH_WDAT: begin
                            d.oe    = 1'b1;
                            d.wr    = 1'b1;
                            d.waddr = q.ptr;
                            d.wdata = q.sh;
                            d.ptr   = q.ptr + 1'b1;
                        end
                        PH_RDAT: begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + 1'b1;
                        end
                        default: d.oe = 1'b0;
                    endcase
                end else if (q.ph == PH_RDAT && q.bits != 4'd0) begin
                    d.tx = {q.tx[6:0], 1'b0};
                    d.oe = ~q.tx[6];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign ptr_o     = q.ptr;
    assign wr_en_o   = q.wr;
    assign wr_addr_o = q.waddr;
    assign wr_data_o = q.wdata;
    assign cap_o     = q.cap;
    assign phase_o   = q.ph;
endmodule

// File: rtl/srb_regs.sv
module srb_regs #(
    parameter int         NREG      = 16,
    parameter int         CNT_LO    = 1,
    parameter int         CNT_HI    = 7,
    parameter int         MASK_BIT  = 3,
    parameter int         YEAR_LOC  = 5,
    parameter logic [7:0] YEAR_MASK = 8'hC0,
    parameter int         WDAY_LOC  = 6,
    parameter logic [7:0] WDAY_MASK = 8'hE0,
    localparam int        AW        = $clog2(NREG),
    localparam int        NCNT      = CNT_HI - CNT_LO + 1,
    localparam int        LW        = $clog2(CNT_HI + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              ld_en_i,
    input  logic [LW-1:0]     ld_idx_i,
    input  logic [7:0]        ld_data_i,
    input  logic              cap_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [7:0]        rd_byte_o,
    output logic [7:0]        ctrl_o,
    output logic [NCNT*8-1:0] counters_o,
    output logic [NCNT*8-1:0] snap_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0] mem;
        logic [NCNT-1:0][7:0] snap;
    } regs_t;

    regs_t      q, d;
    logic [7:0] raw;

    always_comb begin
        d = q;
        if (ld_en_i && int'(ld_idx_i) >= CNT_LO && int'(ld_idx_i) <= CNT_HI)
            d.mem[AW'(ld_idx_i)] = ld_data_i;
        if (wr_en_i)
            d.mem[wr_addr_i] = wr_data_i;
        if (cap_i) begin
            for (int i = 0; i < NCNT; i++)
                d.snap[i] = q.mem[CNT_LO + i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        raw = q.mem[rd_addr_i];
        for (int i = 0; i < NCNT; i++) begin
            if (rd_addr_i == AW'(CNT_LO + i)) raw = q.snap[i];
        end
        rd_byte_o = raw;
        if (q.mem[0][MASK_BIT]) begin
            if (rd_addr_i == AW'(YEAR_LOC)) rd_byte_o = raw & ~YEAR_MASK;
            if (rd_addr_i == AW'(WDAY_LOC)) rd_byte_o = raw & ~WDAY_MASK;
        end
    end

    assign ctrl_o = q.mem[0];
    assign snap_o = q.snap;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        assign counters_o[8*g +: 8] = q.mem[CNT_LO + g];
    end
endmodule

// File: rtl/srb_bank.sv
module srb_bank
    import srb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h51,
    parameter int         NREG        = 16,
    parameter int         CNT_LO      = 1,
    parameter int         CNT_HI      = 7,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(NREG),
    localparam int        NCNT        = CNT_HI - CNT_LO + 1,
    localparam int        LW          = $clog2(CNT_HI + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              ld_en_i,
    input  logic [LW-1:0]     ld_idx_i,
    input  logic [7:0]        ld_data_i,
    output logic [7:0]        ctrl_o,
    output logic [NCNT*8-1:0] counters_o
);
    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0]        rd_byte;
    logic [AW-1:0]     ptr;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [7:0]        wr_data;
    logic              cap;
    phase_e            phase;
    logic [NCNT*8-1:0] snap;

    srb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    srb_link #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s_i   (sda_s),
        .rise_i    (scl_rise),
        .fall_i    (scl_fall),
        .start_i   (bus_start),
        .stop_i    (bus_stop),
        .rd_byte_i (rd_byte),
        .sda_oe_o  (sda_oe_o),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .cap_o     (cap),
        .phase_o   (phase)
    );

    srb_regs #(.NREG(NREG), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .ld_en_i    (ld_en_i),
        .ld_idx_i   (ld_idx_i),
        .ld_data_i  (ld_data_i),
        .cap_i      (cap),
        .rd_addr_i  (ptr),
        .rd_byte_o  (rd_byte),
        .ctrl_o     (ctrl_o),
        .counters_o (counters_o),
        .snap_o     (snap)
    );
endmodule

// File: rtl/srb_bank_chk.sv
module srb_bank_chk
    import srb_pkg::*;
#(
    parameter int AW   = 4,
    parameter int NCNT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              bus_stop,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [AW-1:0]     ptr,
    input logic              cap,
    input phase_e            phase,
    input logic [NCNT*8-1:0] snap,
    input logic [NCNT*8-1:0] live
);
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !sda_oe); // R1

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe); // R5

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == AW'(wr_addr + 1'b1))); // R3

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (snap == $past(live))); // R6

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(snap)); // R6
endmodule

bind srb_bank srb_bank_chk #(.AW(AW), .NCNT(NCNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .bus_stop (bus_stop),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ptr      (ptr),
    .cap      (cap),
    .phase    (phase),
    .snap     (snap),
    .live     (counters_o)
);

// File: tb/sim_srb_bank.sv
`timescale 1ns/1ps
module sim_srb_bank;
    localparam int T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [7:0]  ld_data = '0;
    logic [7:0]  ctrl;
    logic [55:0] counters;
    logic [55:0] exp_cnt;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    srb_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .ld_en_i    (ld_en),
        .ld_idx_i   (ld_idx),
        .ld_data_i  (ld_data),
        .ctrl_o     (ctrl),
        .counters_o (counters)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b0; wt(T);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b1; wt(T);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(T);
            m_scl = 1'b1; wt(T);
            m_scl = 1'b0; wt(T);
        end
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        ack = ~sda_line;
        m_scl = 1'b0; wt(T);
    endtask

    task automatic recv(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(T);
            m_scl = 1'b1; wt(T);
            b[i] = sda_line;
            m_scl = 1'b0;
        end
        wt(T);
        m_sda = nack; wt(T);
        m_scl = 1'b1; wt(T);
        m_scl = 1'b0; wt(T);
        m_sda = 1'b1;
    endtask

    task automatic load(input logic [2:0] idx, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // set pointer via write phase, then repeated START into read
    task automatic point_read(input logic [7:0] addr, input string req);
        logic a;
        bus_start();
        send(8'hA2, a); chk({req, " ack dev-w"}, a, 1);
        send(addr, a);  chk({req, " ack word"}, a, 1);
        bus_start();
        send(8'hA3, a); chk({req, " ack dev-r"}, a, 1);
    endtask

    task automatic t_reset();
        chk("R12 sda released", sda_oe, 0);
        chk("R12 ctrl zero", ctrl, 0);
        chk("R12 counters zero", counters, 0);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send(8'hA4, a); chk("R1 foreign address not acked", a, 0);
        send(8'hA2, a); chk("R1 silent until START", a, 0);
        bus_stop();
    endtask

    task automatic t_ram();
        logic a;
        logic [7:0] b;
        bus_start();
        send(8'hA2, a); chk("R2 ack A2h", a, 1);
        send(8'h08, a); chk("R2 ack word", a, 1);
        for (int i = 0; i < 4; i++) begin
            send(8'hA0 + 8'(i), a); chk("R2 ack data", a, 1);
        end
        bus_stop();
        point_read(8'h08, "R4");
        for (int i = 0; i < 4; i++) begin
            recv(i == 3, b); chk("R11 RAM readback", b, 8'hA0 + 8'(i));
        end
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        logic [7:0] b;
        bus_start();
        send(8'hA2, a);
        send(8'h0F, a);
        send(8'h5C, a);
        send(8'h41, a);
        bus_stop();
        chk("R3 wrap 0F->00 wrote ctrl", ctrl, 8'h41);
        point_read(8'h0F, "R3");
        recv(0, b); chk("R3 loc 0F", b, 8'h5C);
        recv(1, b); chk("R3 read wrap to 00", b, 8'h41);
        bus_stop();
    endtask

    task automatic t_counters();
        logic a;
        for (int i = 1; i <= 7; i++) begin
            load(3'(i), 8'(8'h11 * i));
            exp_cnt[8*(i-1) +: 8] = 8'(8'h11 * i);
        end
        chk("R9 load port", counters, exp_cnt);
        load(3'd0, 8'hEE);
        wt(2);
        chk("R9 index 0 ctrl untouched", ctrl, 8'h41);
        chk("R9 index 0 counters untouched", counters, exp_cnt);
        bus_start();
        send(8'hA2, a);
        send(8'h03, a);
        send(8'h3C, a);
        bus_stop();
        exp_cnt[16 +: 8] = 8'h3C;
        chk("R8 single counter write", counters, exp_cnt);
    endtask

    task automatic t_snapshot();
        logic [7:0] b;
        logic [55:0] old;
        old = exp_cnt;
        point_read(8'h01, "R6");
        recv(0, b); chk("R6 loc 01", b, old[7:0]);
        load(3'd2, 8'h99);
        load(3'd3, 8'h98);
        exp_cnt[8 +: 8] = 8'h99;
        exp_cnt[16 +: 8] = 8'h98;
        for (int i = 2; i <= 7; i++) begin
            recv(i == 7, b); chk("R6 frozen copy", b, old[8*(i-1) +: 8]);
        end
        bus_stop();
        chk("R6 live counters changed", counters, exp_cnt);
        bus_start();
        send(8'hA3, b[0]); chk("R4 ack plain read", b[0], 1);
        recv(1, b); chk("R4 continues at pointer 08", b, 8'hA0);
        bus_stop();
    endtask

    task automatic t_refresh();
        logic [7:0] b;
        point_read(8'h02, "R7");
        recv(1, b); chk("R7 new copy on read", b, 8'h99);
        load(3'd2, 8'h5A);
        point_read(8'h02, "R7");
        recv(1, b); chk("R7 repeated START refreshes", b, 8'h5A);
        bus_stop();
        exp_cnt[8 +: 8] = 8'h5A;
    endtask

    task automatic t_mask();
        logic a;
        logic [7:0] b;
        bus_start();
        send(8'hA2, a);
        send(8'h00, a);
        send(8'h08, a);
        bus_start();
        send(8'hA2, a);
        send(8'h05, a);
        send(8'hE5, a);
        send(8'hF2, a);
        bus_stop();
        point_read(8'h05, "R10");
        recv(0, b); chk("R10 year blanked", b, 8'h25);
        recv(1, b); chk("R10 weekday blanked", b, 8'h12);
        bus_stop();
        chk("R10 stored year kept", counters[32 +: 8], 8'hE5);
        chk("R10 stored weekday kept", counters[40 +: 8], 8'hF2);
        bus_start();
        send(8'hA2, a);
        send(8'h00, a);
        send(8'h00, a);
        bus_stop();
        point_read(8'h05, "R10");
        recv(1, b); chk("R10 unmasked read", b, 8'hE5);
        bus_stop();
    endtask

    task automatic t_nack();
        logic [7:0] b;
        point_read(8'h09, "R5");
        recv(1, b); chk("R5 byte before NACK", b, 8'hA1);
        recv(1, b); chk("R5 released after NACK", b, 8'hFF);
        chk("R5 sda released", sda_oe, 0);
        bus_stop();
        chk("R5 released after STOP", sda_oe, 0);
    endtask

    initial begin
        exp_cnt = '0;
        wt(4);
        rst_n = 1'b1;
        wt(4);
        t_reset();
        t_bad_addr();
        t_ram();
        t_wrap();
        t_counters();
        t_snapshot();
        t_refresh();
        t_mask();
        t_nack();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule